// File: doc/BRIEF.md
# Dual Counter GPIO Blink Generator

This block drives a bank of GPIO output pins. Each pin shows either a static level or a blinking waveform. Two independent duration generators run all the time. Each one alternates between a high phase and a low phase, and software programs the length of each phase as a count of core clock cycles. Every pin has a blink enable bit and a counter-select bit. A pin with blinking disabled shows its bit of the static output register. A pin with blinking enabled shows the phase of the generator that its select bit names.

Software programs the block through a simple write port. Register addresses are byte offsets. Deciding which pins share a generator is left to software; the block does no arbitration. The period of a generator is on+off cycles and its duty ratio is on/(on+off). Every pin output is registered.

Top module: `gpio_blink_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every bit of `pin_o` is 0. Both generators leave reset in their high phase.
- R2: A pin whose blink enable bit is 0 drives its bit of the static output register (offset 0x00). The new value appears on `pin_o` on the second rising edge after the write is presented, which is one edge after the register update.
- R3: A generator spends exactly ON cycles with its phase high and then exactly OFF cycles with its phase low, and repeats this without end. A blink-enabled pin follows that phase one cycle after the generator.
- R4: Bit n of the select register (offset 0x20) routes generator 0 (bit = 0) or generator 1 (bit = 1) to pin n. Bit n of the blink enable register (offset 0x08) turns blinking on for pin n.
- R5: A duration value of 0 acts as 1 cycle.
- R6: A write to the ON register (set k at 0x40+8k) or the OFF register (0x44+8k) of a set restarts that set at the start of its high phase. The restart happens on the edge after the register takes the new value, even when that edge is also the end of a phase. The other set keeps running undisturbed.
- R7: All pins that select the same generator toggle in the same cycles.
- R8: A write to an address that maps to no register changes no register and no pin.
- R9: Durations use all 32 bits. Values above 255 count in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; durations are counted in cycles of this clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | ADDR_W (8) | Byte offset of the register being written |
| wr_data | input | DATA_W (32) | Write data |
| pin_o | output | NPINS (32) | Registered pin levels |

## Verification
Two functions can fall in the same cycle. One is a restart caused by a duration write; the other is the generator's own end-of-phase reload. The bench provokes the overlap by setting both durations of a set to 1, so every edge ends a phase. It then writes the ON register several times with different cycle parities, so the restart reaches the generator both while the phase is high and while it is low. It judges the result by requiring the pin to be high on the third edge after each write and then to alternate every cycle. The generator on the other pins must keep the alignment it had before the writes.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
  localparam int NSETS = 2;

  localparam int OFS_OUT      = 'h00;
  localparam int OFS_BLINK_EN = 'h08;
  localparam int OFS_SEL      = 'h20;
  localparam int OFS_SET_BASE = 'h40;
  localparam int SET_STRIDE   = 8;
  localparam int OFS_ON       = 0;
  localparam int OFS_OFF      = 4;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/gpio_blink_regs.sv
module gpio_blink_regs
  import gpio_blink_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DUR_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NPINS-1:0]             out_q,
  output logic [NPINS-1:0]             en_q,
  output logic [NPINS-1:0]             sel_q,
  output logic [NSETS-1:0][DUR_W-1:0]  on_q,
  output logic [NSETS-1:0][DUR_W-1:0]  off_q,
  output logic [NSETS-1:0]             restart_q
);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_BLINK_EN);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      en_q  <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_OUT) out_q <= wr_data[NPINS-1:0];
      if (wr_addr == A_EN)  en_q  <= wr_data[NPINS-1:0];
      if (wr_addr == A_SEL) sel_q <= wr_data[NPINS-1:0];
    end
  end

  for (genvar k = 0; k < NSETS; k++) begin : g_set
    localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(OFS_SET_BASE + k*SET_STRIDE + OFS_ON);
    localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(OFS_SET_BASE + k*SET_STRIDE + OFS_OFF);
    logic [DUR_W-1:0] on_r, off_r;
    logic             rs_r;
    logic             hit_on, hit_off;

    assign hit_on  = wr_en && (wr_addr == A_ON);
    assign hit_off = wr_en && (wr_addr == A_OFF);

    always_ff @(posedge clk) begin
      if (rst) begin
        on_r  <= DUR_W'(1);
        off_r <= DUR_W'(1);
        rs_r  <= 1'b0;
      end else begin
        rs_r <= hit_on || hit_off;
        if (hit_on)  on_r  <= wr_data[DUR_W-1:0];
        if (hit_off) off_r <= wr_data[DUR_W-1:0];
      end
    end

    assign on_q[k]      = on_r;
    assign off_q[k]     = off_r;
    assign restart_q[k] = rs_r;
  end
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer
  import gpio_blink_pkg::*;
#(
  parameter int DUR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DUR_W-1:0] on_dur,
  input  logic [DUR_W-1:0] off_dur,
  output logic             phase_o
);
  logic [DUR_W-1:0] on_eff, off_eff, left_q;
  phase_e           ph_q;

  assign on_eff  = (on_dur  == '0) ? DUR_W'(1) : on_dur;
  assign off_eff = (off_dur == '0) ? DUR_W'(1) : off_dur;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_HIGH;
      left_q <= DUR_W'(1);
    end else if (restart) begin
      ph_q   <= PH_HIGH;
      left_q <= on_eff;
    end else if (left_q == DUR_W'(1)) begin
      if (ph_q == PH_HIGH) begin
        ph_q   <= PH_LOW;
        left_q <= off_eff;
      end else begin
        ph_q   <= PH_HIGH;
        left_q <= on_eff;
      end
    end else begin
      left_q <= left_q - DUR_W'(1);
    end
  end

  assign phase_o = (ph_q == PH_HIGH);
endmodule

// File: rtl/gpio_blink_pinmux.sv
module gpio_blink_pinmux
  import gpio_blink_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] en_q,
  input  logic [NPINS-1:0] sel_q,
  input  logic [NSETS-1:0] phase,
  output logic [NPINS-1:0] pin_o
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic p_q;
    always_ff @(posedge clk) begin
      if (rst)           p_q <= 1'b0;
      else if (en_q[i])  p_q <= phase[sel_q[i]];
      else               p_q <= out_q[i];
    end
    assign pin_o[i] = p_q;
  end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen
  import gpio_blink_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DUR_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NPINS-1:0]  pin_o
);
  logic [NPINS-1:0]            out_q, en_q, sel_q;
  logic [NSETS-1:0][DUR_W-1:0] on_q, off_q;
  logic [NSETS-1:0]            restart;
  logic [NSETS-1:0]            phase;

  gpio_blink_regs #(
    .NPINS(NPINS), .DUR_W(DUR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_q(out_q), .en_q(en_q), .sel_q(sel_q),
    .on_q(on_q), .off_q(off_q), .restart_q(restart)
  );

  for (genvar k = 0; k < NSETS; k++) begin : g_tmr
    gpio_blink_timer #(.DUR_W(DUR_W)) u_tmr (
      .clk(clk), .rst(rst), .restart(restart[k]),
      .on_dur(on_q[k]), .off_dur(off_q[k]), .phase_o(phase[k])
    );
  end

  gpio_blink_pinmux #(.NPINS(NPINS)) u_mux (
    .clk(clk), .rst(rst), .out_q(out_q), .en_q(en_q), .sel_q(sel_q),
    .phase(phase), .pin_o(pin_o)
  );
endmodule

// File: rtl/gpio_blink_checker.sv
module gpio_blink_checker
  import gpio_blink_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pin_o,
  input logic [NPINS-1:0] out_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] sel_q,
  input logic [NSETS-1:0] restart,
  input logic [NSETS-1:0] phase
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_o == '0));

  assert_static_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (pin_o & ~$past(en_q)) == ($past(out_q) & ~$past(en_q)));

  assert_blink_route_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_o & $past(en_q)) ==
    ($past(en_q) & (($past(sel_q) & {NPINS{$past(phase[1])}}) |
                    (~$past(sel_q) & {NPINS{$past(phase[0])}}))));

  for (genvar k = 0; k < NSETS; k++) begin : g_chk
    assert_restart_high_R6: assert property (@(posedge clk) disable iff (rst)
      restart[k] |=> phase[k]);
  end
endmodule

bind gpio_blink_gen gpio_blink_checker #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .pin_o(pin_o), .out_q(out_q), .en_q(en_q),
  .sel_q(sel_q), .restart(restart), .phase(phase)
);

// File: tb/tb_gpio_blink_gen.sv
`timescale 1ns/1ps
module tb_gpio_blink_gen;
  localparam int NPINS = 32, DUR_W = 32, DATA_W = 32, ADDR_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [NPINS-1:0]  pin_o;

  gpio_blink_gen #(.NPINS(NPINS), .DUR_W(DUR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pin_o(pin_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  logic [NPINS-1:0] m_out = '0, m_en = '0, m_sel = '0;
  int m_on[2], m_off[2], m_t0[2];

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // after the last duration write, the pin shows the high phase on the third edge
  task automatic set_dur(input int k, input int on, input int off);
    wr(ADDR_W'('h40 + 8*k), DATA_W'(on));
    wr(ADDR_W'('h44 + 8*k), DATA_W'(off));
    m_on[k]  = (on  == 0) ? 1 : on;
    m_off[k] = (off == 0) ? 1 : off;
    m_t0[k]  = cyc + 2;
    @(negedge clk);
  endtask

  task automatic rewrite_on(input int k, input int on);
    wr(ADDR_W'('h40 + 8*k), DATA_W'(on));
    m_on[k] = (on == 0) ? 1 : on;
    m_t0[k] = cyc + 2;
    @(negedge clk);
  endtask

  function automatic logic wave(input int k);
    int p, i;
    p = m_on[k] + m_off[k];
    i = (cyc - m_t0[k]) % p;
    return i < m_on[k];
  endfunction

  function automatic logic [NPINS-1:0] exp_vec();
    return (m_out & ~m_en) | (m_en & ~m_sel & {NPINS{wave(0)}})
         | (m_en & m_sel & {NPINS{wave(1)}});
  endfunction

  task automatic check_span(input int n, input string tag);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      n_chk++;
      if (pin_o !== exp_vec()) begin
        n_bad++;
        $display("FAIL %s: pin_o=%h expected %h (cycle %0d)", tag, pin_o, exp_vec(), cyc);
      end
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (pin_o !== '0) begin
      n_bad++;
      $display("FAIL R1: pin_o=%h expected %h", pin_o, {NPINS{1'b0}});
    end
  endtask

  task automatic t_static;
    wr(8'h00, 32'hA5A5_0F0F); m_out = 32'hA5A5_0F0F;
    check_span(3, "R2");
    wr(8'h00, 32'h1234_8001); m_out = 32'h1234_8001;
    check_span(2, "R2");
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    check_span(4, "R8");
  endtask

  task automatic t_set0;
    wr(8'h20, 32'h0); m_sel = '0;
    wr(8'h08, 32'h0000_0021); m_en = 32'h0000_0021;
    set_dur(0, 3, 5);
    for (int s = 0; s < 24; s++) begin
      @(negedge clk);
      n_chk++;
      if (pin_o !== exp_vec()) begin
        n_bad++;
        $display("FAIL R3: pin_o=%h expected %h", pin_o, exp_vec());
      end
      n_chk++;
      if (pin_o[0] !== pin_o[5]) begin
        n_bad++;
        $display("FAIL R7: pin0=%b expected pin5=%b", pin_o[0], pin_o[5]);
      end
    end
  endtask

  task automatic t_set1;
    wr(8'h20, 32'h0000_0300); m_sel = 32'h0000_0300;
    wr(8'h08, 32'h0000_0321); m_en = 32'h0000_0321;
    set_dur(1, 2, 1);
    check_span(18, "R4");
  endtask

  task automatic t_zero;
    set_dur(1, 0, 0);
    check_span(10, "R5");
  endtask

  task automatic t_restart;
    set_dur(0, 1, 1);
    check_span(5, "R6");
    @(negedge clk);
    rewrite_on(0, 1);
    check_span(5, "R6");
    rewrite_on(0, 1);
    check_span(4, "R6");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rewrite_on(0, 1);
    check_span(6, "R6");
  endtask

  task automatic t_wide;
    wr(8'h20, 32'h8000_0300); m_sel = 32'h8000_0300;
    wr(8'h08, 32'h8000_0321); m_en = 32'h8000_0321;
    set_dur(1, 'h101, 3);
    check_span('h101 + 3 + 8, "R9");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_static();
    t_set0();
    t_set1();
    t_zero();
    t_restart();
    t_wide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run still active at cycle %0d, expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule